// File: doc/BRIEF.md
# Accumulator Processor with Microsequenced Control

This block is a small stored-program processor built around one working register, the accumulator. It holds a program counter, a memory address register, an instruction register and the accumulator, and shares a single ALU for data operations and for stepping the program counter. A four-state sequencer fetches one-word instructions from an external memory, decodes them and runs eleven operations: load, store, add, reverse subtract, AND, OR, XOR, input, output, jump and jump-if-zero.

The memory address bus is driven only by the address register. The memory's read port must present the word at `mem_addr` within the same cycle; writes take effect on the rising clock edge while `mem_we` is high. An 8-bit word holds a 4-bit opcode in its upper half and a 4-bit address in its lower half, so programs and data share a 16-word space. Every instruction takes exactly four cycles, walking the states FETCH_ADDR, FETCH_INC, LOAD_IR and EXEC in that order. The transitions are addr_to_inc, inc_to_load, load_to_exec and exec_to_fetch, and each of them is unconditional.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears PC, MAR and accumulator to zero and enters FETCH_ADDR. While in reset, `mem_addr` is 0, `mem_we` is 0, `out_data` is 0 and `out_strobe` is 0.
- R2: Each instruction takes four cycles. In FETCH_ADDR the ALU passes PC into MAR. In FETCH_INC the ALU writes PC+1 back to PC. As a result, after reset the bus first shows address 0, and the next fetch shows address 1.
- R3: In LOAD_IR the word on `mem_rdata` is split in one cycle: bits [7:4] go to the instruction register and bits [3:0] go to MAR. From then on, `mem_addr` shows that address field.
- R4: Opcode values are 1 LDA, 2 ADD, 3 SUB, 4 OR, 5 AND, 6 XOR, 7 INA, 8 OUT, 9 JMP, A JMZ and B STO. LDA copies the memory word at the address field into the accumulator.
- R5: ADD sets the accumulator to accumulator plus memory word, modulo 256.
- R6: SUB sets the accumulator to the memory word minus the accumulator, modulo 256. The operand order is fixed this way.
- R7: AND, OR and XOR combine the accumulator bitwise with the memory word and write the result to the accumulator.
- R8: STO writes the accumulator to the memory word at the address field. `mem_we` is high for exactly one cycle.
- R9: INA copies `in_data` into the accumulator.
- R10: OUT copies the accumulator into `out_data` and raises `out_strobe` for exactly one cycle, beginning the cycle after EXEC.
- R11: JMP loads PC with the address field, so the next fetch comes from that address.
- R12: JMZ loads PC with the address field only when the accumulator is zero. Otherwise execution continues with the next word.
- R13: Opcodes 0 and C to F change neither the accumulator nor the outputs, and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 4 | Memory address, the MAR contents |
| mem_rdata | input | 8 | Word at `mem_addr`, valid within the cycle |
| mem_wdata | output | 8 | Store data, the accumulator |
| mem_we | output | 1 | Memory write enable, one cycle per store |
| in_data | input | 8 | External input sampled by INA |
| out_data | output | 8 | Registered output loaded by OUT |
| out_strobe | output | 1 | One-cycle pulse after each OUT |

## Verification
The bench targets the operand order of SUB: with 5 in the accumulator and 3 in memory, a design that subtracts the wrong way round would give 02 instead of FE. An ADD that overflows must wrap to the low byte. JMZ is run both taken and not taken, and each path emits a different output value, so an inverted or ignored zero test is visible. The bench watches the fetch addresses 0, field and 1 cycle by cycle, which exposes a PC incremented before its copy or an IR and MAR loaded in different cycles. It also checks that undefined opcodes and a mid-run reset leave no stray accumulator value or strobe.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPW = 4;

    typedef enum logic [1:0] {
        S_FETCH_ADDR,
        S_FETCH_INC,
        S_LOAD_IR,
        S_EXEC
    } state_e;

    typedef enum logic [3:0] {
        OP_NOP = 4'h0,
        OP_LDA = 4'h1,
        OP_ADD = 4'h2,
        OP_SUB = 4'h3,
        OP_OR  = 4'h4,
        OP_AND = 4'h5,
        OP_XOR = 4'h6,
        OP_INA = 4'h7,
        OP_OUT = 4'h8,
        OP_JMP = 4'h9,
        OP_JMZ = 4'hA,
        OP_STO = 4'hB
    } opcode_e;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUBR,
        FN_BINC,
        FN_AND,
        FN_OR,
        FN_XOR
    } alu_fn_e;

    typedef enum logic [1:0] {
        BS_MEM,
        BS_IN,
        BS_PC,
        BS_MAR
    } bsel_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    cin;
        bsel_e   bsel;
        logic    ld_pc;
        logic    ld_mar;
        logic    ld_ir;
        logic    ld_acc;
        logic    wr_mem;
        logic    ld_out;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    input  logic         cin,
    output logic [W-1:0] y
);

    logic [W-1:0] cin_w;
    assign cin_w = W'(cin);

    always_comb begin
        unique case (fn)
            FN_ADD:  y = a + b + cin_w;
            FN_SUBR: y = b + ~a + cin_w;
            FN_BINC: y = b + cin_w;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    input  logic           acc_zero,
    output state_e         state,
    output ctl_t           ctl
);

    state_e state_q;
    state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_FETCH_ADDR;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // transitions: addr_to_inc, inc_to_load, load_to_exec, exec_to_fetch
    always_comb begin
        unique case (state_q)
            S_FETCH_ADDR: state_d = S_FETCH_INC;
            S_FETCH_INC:  state_d = S_LOAD_IR;
            S_LOAD_IR:    state_d = S_EXEC;
            S_EXEC:       state_d = S_FETCH_ADDR;
            default:      state_d = S_FETCH_ADDR;
        endcase
    end

    always_comb begin
        ctl        = '0;
        ctl.fn     = FN_BINC;
        ctl.bsel   = BS_MEM;
        unique case (state_q)
            S_FETCH_ADDR: begin
                ctl.bsel   = BS_PC;
                ctl.ld_mar = 1'b1;
            end
            S_FETCH_INC: begin
                ctl.bsel  = BS_PC;
                ctl.cin   = 1'b1;
                ctl.ld_pc = 1'b1;
            end
            S_LOAD_IR: begin
                ctl.bsel   = BS_MEM;
                ctl.ld_ir  = 1'b1;
                ctl.ld_mar = 1'b1;
            end
            S_EXEC: begin
                case (opcode_e'(opcode))
                    OP_LDA: ctl.ld_acc = 1'b1;
                    OP_ADD: begin
                        ctl.fn     = FN_ADD;
                        ctl.ld_acc = 1'b1;
                    end
                    OP_SUB: begin
                        ctl.fn     = FN_SUBR;
                        ctl.cin    = 1'b1;
                        ctl.ld_acc = 1'b1;
                    end
                    OP_OR: begin
                        ctl.fn     = FN_OR;
                        ctl.ld_acc = 1'b1;
                    end
                    OP_AND: begin
                        ctl.fn     = FN_AND;
                        ctl.ld_acc = 1'b1;
                    end
                    OP_XOR: begin
                        ctl.fn     = FN_XOR;
                        ctl.ld_acc = 1'b1;
                    end
                    OP_INA: begin
                        ctl.bsel   = BS_IN;
                        ctl.ld_acc = 1'b1;
                    end
                    OP_OUT: ctl.ld_out = 1'b1;
                    OP_JMP: begin
                        ctl.bsel  = BS_MAR;
                        ctl.ld_pc = 1'b1;
                    end
                    OP_JMZ: begin
                        ctl.bsel  = BS_MAR;
                        ctl.ld_pc = acc_zero;
                    end
                    OP_STO: ctl.wr_mem = 1'b1;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst,
    output logic [DW-OPW-1:0]   mem_addr,
    input  logic [DW-1:0]       mem_rdata,
    output logic [DW-1:0]       mem_wdata,
    output logic                mem_we,
    input  logic [DW-1:0]       in_data,
    output logic [DW-1:0]       out_data,
    output logic                out_strobe
);

    localparam int AW = DW - OPW;

    logic [AW-1:0]  pc_q;
    logic [AW-1:0]  mar_q;
    logic [OPW-1:0] ir_q;
    logic [DW-1:0]  acc_q;
    logic [DW-1:0]  out_q;
    logic           strobe_q;
    logic [DW-1:0]  alu_b;
    logic [DW-1:0]  alu_y;
    state_e         cur_state;
    ctl_t           ctl;

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (ir_q),
        .acc_zero (acc_q == '0),
        .state    (cur_state),
        .ctl      (ctl)
    );

    always_comb begin
        unique case (ctl.bsel)
            BS_MEM:  alu_b = mem_rdata;
            BS_IN:   alu_b = in_data;
            BS_PC:   alu_b = {{OPW{1'b0}}, pc_q};
            BS_MAR:  alu_b = {{OPW{1'b0}}, mar_q};
            default: alu_b = '0;
        endcase
    end

    acc_cpu_alu #(.W(DW)) u_alu (
        .a   (acc_q),
        .b   (alu_b),
        .fn  (ctl.fn),
        .cin (ctl.cin),
        .y   (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            mar_q    <= '0;
            ir_q     <= '0;
            acc_q    <= '0;
            out_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            if (ctl.ld_pc)  pc_q  <= alu_y[AW-1:0];
            if (ctl.ld_mar) mar_q <= alu_y[AW-1:0];
            if (ctl.ld_ir)  ir_q  <= alu_y[DW-1:AW];
            if (ctl.ld_acc) acc_q <= alu_y;
            if (ctl.ld_out) out_q <= acc_q;
            strobe_q <= ctl.ld_out;
        end
    end

    assign mem_addr   = mar_q;
    assign mem_wdata  = acc_q;
    assign mem_we     = ctl.wr_mem;
    assign out_data   = out_q;
    assign out_strobe = strobe_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input logic                clk,
    input logic                rst,
    input state_e              state,
    input logic [DW-OPW-1:0]   pc,
    input logic [DW-OPW-1:0]   mar,
    input logic [OPW-1:0]      ir,
    input logic [DW-1:0]       acc,
    input logic [DW-OPW-1:0]   mem_addr,
    input logic [DW-1:0]       mem_rdata,
    input logic                mem_we,
    input logic [DW-1:0]       out_data,
    input logic                out_strobe
);

    localparam int AW = DW - OPW;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (mem_addr == '0 && !out_strobe && acc == '0 && state == S_FETCH_ADDR));

    a_r2_mar_holds_pc: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH_INC) |-> (mem_addr == pc));

    a_r2_pc_steps: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH_INC) |=> (pc == AW'($past(pc) + 1'b1)));

    a_r3_ir_mar_together: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOAD_IR) |=> (mar == $past(mem_rdata[AW-1:0]) && ir == $past(mem_rdata[DW-1:AW])));

    a_r8_single_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
        out_strobe |=> !out_strobe);

    a_r10_out_matches_acc: assert property (@(posedge clk) disable iff (rst)
        out_strobe |-> (out_data == acc));

    a_r12_jmz_not_taken: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && ir == 4'hA && acc != '0) |=> (pc == $past(pc)));

    a_r12_jmz_taken: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && ir == 4'hA && acc == '0) |=> (pc == $past(mar)));

    a_r13_undefined_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && (ir == 4'h0 || ir >= 4'hC)) |=> (acc == $past(acc)));

endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (cur_state),
    .pc         (pc_q),
    .mar        (mar_q),
    .ir         (ir_q),
    .acc        (acc_q),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_we     (mem_we),
    .out_data   (out_data),
    .out_strobe (out_strobe)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mem_addr;
    logic [7:0] mem_rdata;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [7:0] in_data = 8'h00;
    logic [7:0] out_data;
    logic       out_strobe;

    logic       ld_en = 1'b0;
    logic [3:0] ld_a  = 4'h0;
    logic [7:0] ld_d  = 8'h00;
    logic [7:0] mem [16];

    int total = 0;
    int bad   = 0;
    int strobes = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    acc_cpu dut (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .in_data    (in_data),
        .out_data   (out_data),
        .out_strobe (out_strobe)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (ld_en)       mem[ld_a] <= ld_d;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        if (!rst && out_strobe) strobes <= strobes + 1;
    end

    initial begin
        wait (cycles > 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1;
        ld_a  = a;
        ld_d  = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic clear_mem();
        rst = 1'b1;
        for (int i = 0; i < 16; i++) put(4'(i), 8'h00);
    endtask

    task automatic run(input int n);
        @(negedge clk);
        rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // entry: opcode, a (loaded first), b (operand), expected accumulator
    localparam logic [27:0] VEC [11] = '{
        {4'h1, 8'h11, 8'h99, 8'h99},
        {4'h2, 8'h37, 8'h22, 8'h59},
        {4'h2, 8'hF0, 8'h20, 8'h10},
        {4'h3, 8'h05, 8'h03, 8'hFE},
        {4'h3, 8'h10, 8'h30, 8'h20},
        {4'h4, 8'hA0, 8'h0C, 8'hAC},
        {4'h5, 8'hF3, 8'h3C, 8'h30},
        {4'h6, 8'hFF, 8'h0F, 8'hF0},
        {4'hC, 8'h5A, 8'h77, 8'h5A},
        {4'h0, 8'h5A, 8'h77, 8'h5A},
        {4'hF, 8'h81, 8'h01, 8'h81}
    };

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'h1:                tag_of = "R4 LDA";
            4'h2:                tag_of = "R5 ADD";
            4'h3:                tag_of = "R6 SUB";
            4'h4, 4'h5, 4'h6:    tag_of = "R7 logic";
            default:             tag_of = "R13 undefined";
        endcase
    endfunction

    initial begin
        int s0;
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;

        // R1: reset state at the ports
        clear_mem();
        @(negedge clk);
        check("R1 mem_addr", mem_addr, 0);
        check("R1 mem_we", mem_we, 0);
        check("R1 out_data", out_data, 0);
        check("R1 out_strobe", out_strobe, 0);

        // R2/R3: fetch address order 0, field, 1
        put(4'h0, 8'h19);
        put(4'h1, 8'h80);
        run(1);
        check("R2 first fetch address", mem_addr, 0);
        repeat (2) @(negedge clk);
        check("R3 address field on bus", mem_addr, 9);
        repeat (2) @(negedge clk);
        check("R2 next fetch address", mem_addr, 1);

        // vector table: LDA 14; op 15; OUT; JMP 3
        foreach (VEC[k]) begin
            clear_mem();
            put(4'h0, 8'h1E);
            put(4'h1, {VEC[k][27:24], 4'hF});
            put(4'h2, 8'h80);
            put(4'h3, 8'h93);
            put(4'hE, VEC[k][23:16]);
            put(4'hF, VEC[k][15:8]);
            s0 = strobes;
            run(40);
            check(tag_of(VEC[k][27:24]), out_data, int'(VEC[k][7:0]));
            check("R10 one strobe", strobes - s0, 1);
        end

        // R9, R10: INA then OUT
        clear_mem();
        put(4'h0, 8'h70);
        put(4'h1, 8'h80);
        put(4'h2, 8'h92);
        in_data = 8'h6C;
        s0 = strobes;
        run(20);
        check("R9 INA", out_data, 8'h6C);
        check("R10 strobe count", strobes - s0, 1);

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run out_data", out_data, 0);
        check("R1 mid-run mem_addr", mem_addr, 0);
        check("R1 mid-run strobe", out_strobe, 0);

        // R1: accumulator cleared: OUT right after reset gives zero
        clear_mem();
        put(4'h0, 8'h80);
        put(4'h1, 8'h91);
        s0 = strobes;
        run(20);
        check("R1 acc cleared", out_data, 0);
        check("R1 strobe after reset", strobes - s0, 1);

        // R8: INA; STO 13; LDA 14; LDA 13; OUT; JMP 5
        clear_mem();
        put(4'h0, 8'h70);
        put(4'h1, 8'hBD);
        put(4'h2, 8'h1E);
        put(4'h3, 8'h1D);
        put(4'h4, 8'h80);
        put(4'h5, 8'h95);
        in_data = 8'hC3;
        run(40);
        check("R8 stored word", mem[13], 8'hC3);
        check("R8 reload of stored word", out_data, 8'hC3);

        // R11: JMP 3 skips words 1 and 2
        clear_mem();
        put(4'h0, 8'h93);
        put(4'h1, 8'h1F);
        put(4'h2, 8'h80);
        put(4'h3, 8'h1D);
        put(4'h4, 8'h80);
        put(4'h5, 8'h95);
        put(4'hD, 8'h42);
        put(4'hF, 8'h77);
        s0 = strobes;
        run(40);
        check("R11 JMP target", out_data, 8'h42);
        check("R11 strobe count", strobes - s0, 1);

        // R12: JMZ taken and not taken
        for (int t = 0; t < 2; t++) begin
            clear_mem();
            put(4'h0, 8'h1E);
            put(4'h1, 8'hA5);
            put(4'h2, 8'h1F);
            put(4'h3, 8'h80);
            put(4'h4, 8'h94);
            put(4'h5, 8'h1D);
            put(4'h6, 8'h80);
            put(4'h7, 8'h97);
            put(4'hD, 8'h42);
            put(4'hE, (t == 0) ? 8'h00 : 8'h01);
            put(4'hF, 8'h77);
            s0 = strobes;
            run(48);
            check((t == 0) ? "R12 JMZ taken" : "R12 JMZ not taken",
                  out_data, (t == 0) ? 8'h42 : 8'h77);
            check("R12 strobe count", strobes - s0, 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule